// File: doc/BRIEF.md
# Sampling Converter Result Port Controller

This block is the digital back end of a 16-bit sampling converter. A falling edge on an active-low start strobe launches a conversion. A conversion timer then holds a busy flag high for a fixed number of system clocks. When the timer runs out, the block captures the 16-bit word that the analog core presents on a stimulus port. The block then makes that word available to a host.

A strap input chooses how the host reads the word. In parallel mode the whole word appears on a 16-bit bus, and the two bytes can be exchanged. In serial mode only one bus bit is driven. The word leaves on that bit MSB first, paced by a host serial clock that is qualified by chip-select. The bits of the serial input that follow are passed through behind the word, so that several converters can share one line. A coding input chooses offset binary or two's complement. The bus drives only while both the chip-select and read-enable inputs are low. A high reset aborts any conversion and releases the bus. A power-down input blocks new starts.

The conversion controller is a two-state machine:
- CV_IDLE waits for a start.
- CV_RUN counts down the conversion time.

It has three transitions:
- START moves CV_IDLE to CV_RUN on an accepted falling edge.
- FINISH moves CV_RUN to CV_IDLE when the count reaches zero, and captures the result.
- ABORT returns any state to CV_IDLE while reset is high.

Top module: `sar_out_ctl`

## Requirements
- R1: A high-to-low change on `conv_n`, seen on a system clock edge while in CV_IDLE, starts a conversion whatever the chip-select level is. `busy` reads high after that edge.
- R2: `busy` stays high for exactly CONV_CYC system clocks (default 16). In the cycle it falls, the word on `core_res` is captured and becomes the presented result.
- R3: A falling edge on `conv_n` while `busy` is high is ignored. It neither lengthens nor restarts the conversion.
- R4: While `pwr_dn` is high, falling edges on `conv_n` start nothing, and `busy` stays low.
- R5: `bus_en` is nonzero only while `cs_n` and `rd_n` are both low, reset is low, and a result has been captured since reset. Disabled bits of `bus_q` read 0.
- R6: With `code_ob` high the presented word equals the captured word (offset binary). With it low, bit 15 is inverted (two's complement).
- R7: In parallel mode with `swap` low, `bus_q[15:0]` carries the coded word unchanged. With `swap` high, `bus_q[15:8]` carries coded bits 7..0 and `bus_q[7:0]` carries coded bits 15..8.
- R8: With `ser_sel` high, only bus bit 10 (serial out) may be enabled, so `bus_en` is 16'h0400 while reading. Bits 9 and 11 carry the serial input and serial clock on separate ports and are never driven.
- R9: In serial mode, each rising edge of `ser_sck` while `cs_n` is low shifts one bit onto bus bit 10, MSB of the coded word first. The new bit appears three system clocks after the edge and is held until the next rising edge.
- R10: The value of `ser_sdi` sampled at serial edge k appears on bus bit 10 at serial edge k+16.
- R11: While `rst` is high, `busy` is forced low, any conversion in flight is dropped, the captured result is marked invalid, and `bus_en` is zero.
- R12: Raising `cs_n` reloads the serial shifter from the coded result, so the next read starts again at the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset; aborts any conversion |
| conv_n | input | 1 | Conversion start strobe, acts on its falling edge |
| pwr_dn | input | 1 | Power-down; blocks conversion starts |
| cs_n | input | 1 | Active-low chip-select; also qualifies the serial clock |
| rd_n | input | 1 | Active-low read enable |
| ser_sel | input | 1 | High selects serial mode, low selects parallel mode |
| code_ob | input | 1 | High gives offset binary, low gives two's complement |
| swap | input | 1 | Exchanges the bus bytes in parallel mode |
| ser_sck | input | 1 | Serial clock (bus bit 9 role in serial mode is data in, bit 11 is clock) |
| ser_sdi | input | 1 | Serial daisy-chain input |
| core_res | input | 16 | Result word from the analog core |
| busy | output | 1 | High while a conversion runs |
| bus_q | output | 16 | Output data bus value |
| bus_en | output | 16 | Per-bit output driver enable |

## Verification
The assertions assume that `conv_n`, `ser_sck` and `ser_sdi` change only between system clock edges. They also assume that each serial clock level is held for at least three system clocks, so that every rising edge passes the two-stage synchroniser once. The bench drives every input on the falling system edge. It holds each serial clock phase for four system clocks, and it changes `ser_sdi` only together with a rising serial clock. The start strobe is held low for at least one full cycle. Chip-select is held high for several cycles before a serial read, so the shifter has been reloaded.

// File: rtl/sar_out_pkg.sv
package sar_out_pkg;

    typedef enum logic {
        CV_IDLE = 1'b0,
        CV_RUN  = 1'b1
    } cv_state_e;

    // Coding selection: offset binary passes through, two's complement flips the top bit
    function automatic logic [15:0] code_word16(input logic [15:0] raw, input logic ob);
        code_word16 = {raw[15] ^ ~ob, raw[14:0]};
    endfunction

endpackage

// File: rtl/sar_conv_ctl.sv
module sar_conv_ctl
    import sar_out_pkg::*;
#(
    parameter int RES_W    = 16,
    parameter int CONV_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_n,
    input  logic             pwr_dn,
    input  logic [RES_W-1:0] core_res,
    output logic             busy_o,
    output logic             valid_o,
    output logic [RES_W-1:0] res_o
);
    localparam int              CNT_W    = $clog2(CONV_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYC - 1);

    cv_state_e        state_q;
    cv_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             conv_prev_q;
    logic             start_fall;

    assign start_fall = conv_prev_q & ~conv_n;

    // Next-state logic: START and FINISH transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CV_IDLE: if (start_fall && !pwr_dn) state_d = CV_RUN;
            CV_RUN:  if (cnt_q == '0)           state_d = CV_IDLE;
            default:                            state_d = CV_IDLE;
        endcase
    end

    // State register; ABORT on reset
    always_ff @(posedge clk) begin
        if (rst) state_q <= CV_IDLE;
        else     state_q <= state_d;
    end

    // Outputs, timer and result capture
    always_ff @(posedge clk) begin
        if (rst) begin
            conv_prev_q <= 1'b1;
            cnt_q       <= '0;
            busy_o      <= 1'b0;
            valid_o     <= 1'b0;
            res_o       <= '0;
        end else begin
            conv_prev_q <= conv_n;
            busy_o      <= (state_d == CV_RUN);
            if (state_q == CV_IDLE && state_d == CV_RUN)
                cnt_q <= CNT_LOAD;
            else if (state_q == CV_RUN && cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
            if (state_q == CV_RUN && state_d == CV_IDLE) begin
                res_o   <= core_res;
                valid_o <= 1'b1;
            end
        end
    end

    AST_PD_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == CV_IDLE && start_fall && pwr_dn) |=> !busy_o); // R4

    AST_ABORT_CLEARS: assert property (@(posedge clk)
        rst |=> (!busy_o && !valid_o)); // R11

    AST_FINISH_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && !$past(rst)) |-> valid_o); // R2

    generate
        if (CONV_CYC > 1) begin : g_min_busy
            AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
                $rose(busy_o) |=> busy_o); // R2
        end
    endgenerate

endmodule

// File: rtl/sar_fmt.sv
module sar_fmt
    import sar_out_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic [RES_W-1:0] raw,
    input  logic             code_ob,
    input  logic             swap,
    output logic [RES_W-1:0] coded_o,
    output logic [RES_W-1:0] par_o
);
    localparam int HALF = RES_W / 2;

    assign coded_o = code_word16(raw, code_ob);
    assign par_o   = swap ? {coded_o[HALF-1:0], coded_o[RES_W-1:HALF]} : coded_o;

endmodule

// File: rtl/sar_ser_shift.sv
module sar_ser_shift #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             sdi,
    input  logic [RES_W-1:0] load_word,
    output logic             sdo
);
    logic             sck_s1, sck_s2, sck_s3;
    logic             sdi_s1, sdi_s2;
    logic [RES_W-1:0] sr_q;
    logic             sck_rise;

    // Serial clock is qualified by chip-select
    assign sck_rise = sck_s2 & ~sck_s3 & ~cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s1 <= 1'b0;
            sck_s2 <= 1'b0;
            sck_s3 <= 1'b0;
            sdi_s1 <= 1'b0;
            sdi_s2 <= 1'b0;
            sr_q   <= '0;
            sdo    <= 1'b0;
        end else begin
            sck_s1 <= sck;
            sck_s2 <= sck_s1;
            sck_s3 <= sck_s2;
            sdi_s1 <= sdi;
            sdi_s2 <= sdi_s1;
            if (cs_n) begin
                sr_q <= load_word;
                sdo  <= 1'b0;
            end else if (sck_rise) begin
                sdo  <= sr_q[RES_W-1];
                sr_q <= {sr_q[RES_W-2:0], sdi_s2};
            end
        end
    end

    AST_SDO_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && (sck_s2 == sck_s3)) |=> $stable(sdo)); // R9

endmodule

// File: rtl/sar_out_ctl.sv
module sar_out_ctl
    import sar_out_pkg::*;
#(
    parameter int RES_W    = 16,
    parameter int CONV_CYC = 16,
    parameter int SDO_BIT  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_n,
    input  logic             pwr_dn,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             ser_sel,
    input  logic             code_ob,
    input  logic             swap,
    input  logic             ser_sck,
    input  logic             ser_sdi,
    input  logic [RES_W-1:0] core_res,
    output logic             busy,
    output logic [RES_W-1:0] bus_q,
    output logic [RES_W-1:0] bus_en
);
    logic             res_valid;
    logic [RES_W-1:0] res_word;
    logic [RES_W-1:0] coded;
    logic [RES_W-1:0] par_word;
    logic             sdo;
    logic             drive;

    sar_conv_ctl #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_conv (
        .clk      (clk),
        .rst      (rst),
        .conv_n   (conv_n),
        .pwr_dn   (pwr_dn),
        .core_res (core_res),
        .busy_o   (busy),
        .valid_o  (res_valid),
        .res_o    (res_word)
    );

    sar_fmt #(.RES_W(RES_W)) u_fmt (
        .raw      (res_word),
        .code_ob  (code_ob),
        .swap     (swap),
        .coded_o  (coded),
        .par_o    (par_word)
    );

    sar_ser_shift #(.RES_W(RES_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sck       (ser_sck),
        .sdi       (ser_sdi),
        .load_word (coded),
        .sdo       (sdo)
    );

    assign drive = ~rst & res_valid & ~cs_n & ~rd_n;

    always_comb begin
        bus_en = '0;
        bus_q  = '0;
        if (drive) begin
            if (ser_sel) begin
                bus_en[SDO_BIT] = 1'b1;
                bus_q[SDO_BIT]  = sdo;
            end else begin
                bus_en = '1;
                bus_q  = par_word;
            end
        end
    end

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (bus_en == '0)); // R5

    AST_SERIAL_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
        ser_sel |-> ((bus_en & ~(RES_W'(1) << SDO_BIT)) == '0)); // R8

    AST_RESET_RELEASES_BUS: assert property (@(posedge clk)
        rst |-> (bus_en == '0)); // R11

endmodule

// File: tb/sar_out_ctl_test.sv
module sar_out_ctl_test;
    localparam int CYC = 16;

    logic        clk = 1'b0;
    logic        rst, conv_n, pwr_dn, cs_n, rd_n, ser_sel, code_ob, swap, ser_sck, ser_sdi;
    logic [15:0] core_res;
    logic        busy;
    logic [15:0] bus_q, bus_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    sar_out_ctl uut (
        .clk(clk), .rst(rst), .conv_n(conv_n), .pwr_dn(pwr_dn), .cs_n(cs_n), .rd_n(rd_n),
        .ser_sel(ser_sel), .code_ob(code_ob), .swap(swap), .ser_sck(ser_sck), .ser_sdi(ser_sdi),
        .core_res(core_res), .busy(busy), .bus_q(bus_q), .bus_en(bus_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] coded(input logic [15:0] w, input logic ob);
        return {w[15] ^ ~ob, w[14:0]};
    endfunction

    // ---------------- behavioural reference model ----------------
    bit          m_busy = 0, m_valid = 0, m_prev = 1, m_dout = 0;
    int          m_cnt = 0;
    logic [15:0] m_res = '0;
    bit          m_s1 = 0, m_s2 = 0, m_s3 = 0, m_d1 = 0, m_d2 = 0;
    bit          m_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_valid = 0; m_prev = 1; m_cnt = 0; m_res = '0; m_dout = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_d1 = 0; m_d2 = 0;
            m_q.delete();
            for (int i = 0; i < 16; i++) m_q.push_back(1'b0);
        end else begin
            if (cs_n) begin
                m_q.delete();
                for (int i = 15; i >= 0; i--) m_q.push_back(coded(m_res, code_ob)[i]);
                m_dout = 0;
            end else if (m_s2 && !m_s3) begin
                m_dout = m_q.pop_front();
                m_q.push_back(m_d2);
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ser_sck; m_d2 = m_d1; m_d1 = ser_sdi;
            if (m_busy) begin
                if (m_cnt == 0) begin m_busy = 0; m_res = core_res; m_valid = 1; end
                else m_cnt--;
            end else if (m_prev && !conv_n && !pwr_dn) begin
                m_busy = 1; m_cnt = CYC - 1;
            end
            m_prev = conv_n;
        end
    end

    // compare on every clock, away from the edge
    always @(posedge clk) begin
        logic        oe;
        logic [15:0] e_en, e_q, w;
        #5;
        oe   = !rst && m_valid && !cs_n && !rd_n;
        w    = coded(m_res, code_ob);
        e_en = '0; e_q = '0;
        if (oe) begin
            if (ser_sel) begin e_en = 16'h0400; e_q[10] = m_dout; end
            else begin e_en = 16'hFFFF; e_q = swap ? {w[7:0], w[15:8]} : w; end
        end
        chk("R2 model busy", 32'(busy), 32'(m_busy));
        chk("R5 model enable", 32'(bus_en), 32'(e_en));
        chk("R6 model data", 32'(bus_q), 32'(e_q));
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    // counts busy samples over a window; optional second strobe at offset 5
    task automatic run_window(input bit second, output int cnt);
        cnt = 0;
        conv_n = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (busy) cnt++;
            if (k == 0) conv_n = 1'b1;
            if (second && k == 5) conv_n = 1'b0;
            if (second && k == 6) conv_n = 1'b1;
        end
    endtask

    task automatic sck_pulse(input logic din, output logic dout);
        ser_sck = 1'b1; ser_sdi = din;
        repeat (4) @(negedge clk);
        dout = bus_q[10];
        ser_sck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int          n;
        logic        b;
        logic [19:0] sw;
        rst = 1; conv_n = 1; pwr_dn = 0; cs_n = 1; rd_n = 1; ser_sel = 0;
        code_ob = 1; swap = 0; ser_sck = 0; ser_sdi = 0; core_res = 16'hA35C;
        repeat (3) @(negedge clk);
        chk("R11 reset busy", 32'(busy), 32'd0);
        chk("R11 reset bus_en", 32'(bus_en), 32'd0);
        rst = 0;
        @(negedge clk);

        // R1 / R2: start with chip-select high
        run_window(1'b0, n);
        chk("R1 start while cs_n high", 32'(n > 0), 32'd1);
        chk("R2 busy length", 32'(n), 32'(CYC));

        cs_n = 0; rd_n = 0; @(negedge clk);
        chk("R6 offset binary", 32'(bus_q), 32'h0000A35C);
        chk("R5 enable when selected", 32'(bus_en), 32'h0000FFFF);
        code_ob = 0; @(negedge clk);
        chk("R6 twos complement", 32'(bus_q), 32'h0000235C);
        swap = 1; @(negedge clk);
        chk("R7 swap twos", 32'(bus_q), 32'h00005C23);
        code_ob = 1; @(negedge clk);
        chk("R7 swap offset", 32'(bus_q), 32'h00005CA3);
        swap = 0;
        rd_n = 1; @(negedge clk);
        chk("R5 rd_n high", 32'(bus_en), 32'd0);
        cs_n = 1; rd_n = 0; @(negedge clk);
        chk("R5 cs_n high", 32'(bus_en), 32'd0);
        rd_n = 1;

        // R3: second strobe during conversion
        core_res = 16'h1234;
        run_window(1'b1, n);
        chk("R3 strobe while busy", 32'(n), 32'(CYC));
        cs_n = 0; rd_n = 0; @(negedge clk);
        chk("R2 captured word", 32'(bus_q), 32'h00001234);
        cs_n = 1; rd_n = 1;

        // R4: power-down blocks starts
        pwr_dn = 1; core_res = 16'hFFFF;
        run_window(1'b0, n);
        chk("R4 power-down", 32'(n), 32'd0);
        pwr_dn = 0;

        // serial mode
        core_res = 16'hA35C;
        run_window(1'b0, n);
        ser_sel = 1; repeat (3) @(negedge clk);
        cs_n = 0; rd_n = 0; @(negedge clk);
        chk("R8 serial enable", 32'(bus_en), 32'h00000400);
        sw = '0;
        for (int k = 0; k < 20; k++) begin
            sck_pulse((k < 4) ? ((4'b1011 >> (3 - k)) & 1'b1) : 1'b0, b);
            sw = {sw[18:0], b};
        end
        chk("R9 serial MSB first", 32'(sw[19:4]), 32'h0000A35C);
        chk("R10 daisy pass-through", 32'(sw[3:0]), 32'h0000000B);

        // R12: deselect restarts the frame
        cs_n = 1; repeat (3) @(negedge clk);
        cs_n = 0; @(negedge clk);
        sck_pulse(1'b0, b);
        chk("R12 frame restart", 32'(b), 32'd1);
        cs_n = 1; rd_n = 1; ser_sel = 0;

        // R11: abort mid-conversion
        cs_n = 0; rd_n = 0; core_res = 16'h0F0F;
        conv_n = 0; @(negedge clk); conv_n = 1;
        repeat (4) @(negedge clk);
        chk("R11 busy before abort", 32'(busy), 32'd1);
        rst = 1; #1;
        chk("R11 bus released in reset", 32'(bus_en), 32'd0);
        @(negedge clk); rst = 0;
        chk("R11 busy cleared", 32'(busy), 32'd0);
        repeat (20) @(negedge clk);
        chk("R11 no late finish", 32'(busy), 32'd0);
        chk("R11 result invalid", 32'(bus_en), 32'd0);

        finish_run();
    end
endmodule